// File: doc/BRIEF.md
# Lane-Width-Adaptive Flit Reassembler with Check-Byte Verification

This block sits on the receive side of a point-to-point link and rebuilds 80-bit flits from lane words. The lanes form four quadrants of five lanes each. One lane word arrives per clock, qualified by a valid strobe. A start strobe marks the first transfer of every flit. The configured lane mode sets how many lanes carry data: all 20 lanes, the lower 10 lanes, or the lowest 5 lanes. The number of transfers per flit therefore changes with the mode, from 4 to 8 to 16.

When the last transfer of a flit has been captured, the block splits the flit into a 64-bit payload, an 8-bit header and an 8-bit check byte. It then recomputes an 8-bit CRC over the header and payload and reports the flit with a one-cycle valid pulse. A mismatch flag accompanies that pulse when the recomputed CRC differs from the check byte. If a start strobe arrives while a flit is only partly gathered, the block drops the partial flit and starts again from that transfer. It signals this with a framing-error pulse.

Top module: `flit_rx_deser`

## Requirements
- R1: While reset is asserted and after it is released with no input, out_valid, crc_err and frame_err are 0.
- R2: With lane_mode 0 a flit takes 4 accepted transfers of all 20 lanes, and transfer k supplies flit bits [20k+19:20k].
- R3: With lane_mode 1 a flit takes 8 accepted transfers of lanes [9:0], and transfer k supplies flit bits [10k+9:10k].
- R4: With lane_mode 2 or 3 a flit takes 16 accepted transfers of lanes [4:0], and transfer k supplies flit bits [5k+4:5k].
- R5: Lanes outside the active quadrants have no effect on any output.
- R6: The flit fields are payload = bits [63:0], header = bits [71:64] and check byte = bits [79:72]. They appear on out_payload, out_hdr and out_chk.
- R7: crc_err is 1 together with out_valid exactly when the check byte differs from a CRC-8 over flit bits 71 down to 0, fed most significant first. The CRC uses polynomial x^8+x^2+x+1 (0x07), initial value 0, no reflection and no final inversion.
- R8: out_valid is a one-cycle pulse in the cycle after the clock edge that captures a flit's last transfer, and crc_err is never 1 without out_valid.
- R9: Cycles with xfer_valid low are ignored, and their start strobe is ignored too. Gaps inside a flit are allowed. A valid transfer that arrives with no flit in progress and without the start strobe is dropped.
- R10: A valid transfer with the start strobe while a flit is partly gathered drops the partial flit and becomes transfer 0 of a new flit. It also makes frame_err a one-cycle pulse in the next cycle.
- R11: The lane mode is sampled with the start transfer, and changes to lane_mode later in the same flit have no effect on that flit.
- R12: Flits may follow each other with no idle cycle, and each one is reported correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_mode | input | 2 | 0: 20 lanes, 1: 10 lanes, 2 or 3: 5 lanes |
| xfer_valid | input | 1 | Lane word is valid this cycle |
| xfer_sof | input | 1 | Marks the first transfer of a flit |
| lane_word | input | 20 | Lane data; lane 5q+i is bit i of quadrant q |
| out_valid | output | 1 | One-cycle pulse: a rebuilt flit is on the outputs |
| out_hdr | output | 8 | Header field of the last flit |
| out_payload | output | 64 | Payload field of the last flit |
| out_chk | output | 8 | Received check byte of the last flit |
| crc_err | output | 1 | Check byte mismatch, valid with out_valid |
| frame_err | output | 1 | One-cycle pulse: a partial flit was dropped |

## Verification
The checker watches every cycle for the port-level timing rules. These are that out_valid and frame_err are single-cycle pulses, that crc_err only appears with out_valid, that each pulse follows a valid transfer (and, for frame_err, a start strobe), and that a flit report and a framing error never coincide. Only the bench scenarios can show the content-level behaviour. That covers the bit placement of chunks in every lane mode with noise on the idle lanes, and the CRC verdict across random flits and every single-bit corruption. It also covers the recovery after a start strobe mid-flit, mode changes inside a flit, gaps, stray transfers while idle, and back-to-back flits.

// File: rtl/flit_rx_pkg.sv
package flit_rx_pkg;

   // lane-mode encoding at the block's edge
   typedef enum logic [1:0] {
      LM_ALL     = 2'd0,
      LM_HALF    = 2'd1,
      LM_SINGLE  = 2'd2,
      LM_SINGLE2 = 2'd3
   } lane_mode_e;

   // quadrants carrying data in a given mode
   function automatic int unsigned active_quads(input int unsigned mode_i, input int unsigned nq);
      if (mode_i == 0) return nq;
      if (mode_i == 1) return nq / 2;
      return 1;
   endfunction

endpackage

// File: rtl/flit_lane_gather.sv
module flit_lane_gather
   import flit_rx_pkg::*;
#(
   parameter int LPQ    = 5,
   parameter int NQ     = 4,
   parameter int FLIT_W = 80
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                in_sof,
   input  logic [1:0]          in_mode,
   input  logic [LPQ*NQ-1:0]   in_word,
   output logic [FLIT_W-1:0]   flit_o,
   output logic                done_o,
   output logic                frame_err_o
);
   localparam int SLOTS = FLIT_W / LPQ;
   localparam int CNT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam int MODES = 4;

   logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_eff, last_idx;
   logic [1:0]        mode_q, mode_eff;
   logic              busy, accept, done;
   logic [FLIT_W-1:0] asm_q, asm_d;

   always_comb begin
      busy     = (cnt_q != '0);
      cnt_eff  = in_sof ? '0 : cnt_q;
      mode_eff = in_sof ? in_mode : mode_q;
      accept   = in_valid && (in_sof || busy);
      case (mode_eff)
         LM_ALL:  last_idx = CNT_W'(SLOTS / int'(active_quads(0, NQ)) - 1);
         LM_HALF: last_idx = CNT_W'(SLOTS / int'(active_quads(1, NQ)) - 1);
         default: last_idx = CNT_W'(SLOTS - 1);
      endcase
      done  = accept && (cnt_eff == last_idx);
      cnt_d = cnt_q;
      if (accept) cnt_d = done ? '0 : CNT_W'(cnt_eff + 1'b1);
   end

   // each 5-bit slot of the flit picks its quadrant per mode
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [MODES-1:0]          hit;
      logic [MODES-1:0][LPQ-1:0] pick;
      for (genvar m = 0; m < MODES; m++) begin : g_mode
         localparam int Q = int'(active_quads(m, NQ));
         assign hit[m]  = (cnt_eff == CNT_W'(s / Q));
         assign pick[m] = in_word[(s % Q)*LPQ +: LPQ];
      end
      assign asm_d[s*LPQ +: LPQ] = (accept && hit[mode_eff]) ? pick[mode_eff]
                                                             : asm_q[s*LPQ +: LPQ];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mode_q <= LM_ALL;
         asm_q  <= '0;
      end else begin
         cnt_q <= cnt_d;
         asm_q <= asm_d;
         if (in_valid && in_sof) mode_q <= in_mode;
      end
   end

   assign flit_o      = asm_d;
   assign done_o      = done;
   assign frame_err_o = in_valid && in_sof && busy;

endmodule

// File: rtl/flit_crc8.sv
module flit_crc8 #(
   parameter int               DATA_W = 72,
   parameter int               CRC_W  = 8,
   parameter logic [CRC_W-1:0] POLY   = 'h07
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);
   logic [CRC_W-1:0] acc;
   logic             fb;

   always_comb begin
      acc = '0;
      fb  = 1'b0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb  = acc[CRC_W-1] ^ data_i[i];
         acc = {acc[CRC_W-2:0], 1'b0};
         if (fb) acc = acc ^ POLY;
      end
      crc_o = acc;
   end

endmodule

// File: rtl/flit_rx_deser.sv
module flit_rx_deser #(
   parameter int               LANES_PER_QUAD = 5,
   parameter int               NUM_QUADS      = 4,
   parameter int               PAYLOAD_W      = 64,
   parameter int               HDR_W          = 8,
   parameter int               CHK_W          = 8,
   parameter logic [CHK_W-1:0] CHK_POLY       = 'h07
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [1:0]                          lane_mode,
   input  logic                                xfer_valid,
   input  logic                                xfer_sof,
   input  logic [LANES_PER_QUAD*NUM_QUADS-1:0] lane_word,
   output logic                                out_valid,
   output logic [HDR_W-1:0]                    out_hdr,
   output logic [PAYLOAD_W-1:0]                out_payload,
   output logic [CHK_W-1:0]                    out_chk,
   output logic                                crc_err,
   output logic                                frame_err
);
   localparam int FLIT_W = PAYLOAD_W + HDR_W + CHK_W;
   localparam int BODY_W = PAYLOAD_W + HDR_W;
   localparam int LANE_W = LANES_PER_QUAD * NUM_QUADS;

   if (FLIT_W % LANE_W != 0) begin : g_bad_width
      $error("flit width must be a whole number of full-width transfers");
   end
   if (NUM_QUADS < 2 || (NUM_QUADS & (NUM_QUADS - 1)) != 0) begin : g_bad_quads
      $error("quadrant count must be a power of two of at least 2");
   end
   if (CHK_W < 2) begin : g_bad_chk
      $error("check field must be at least 2 bits");
   end

   logic [FLIT_W-1:0] flit;
   logic              done, ferr_c;
   logic [CHK_W-1:0]  chk_calc;

   flit_lane_gather #(
      .LPQ    (LANES_PER_QUAD),
      .NQ     (NUM_QUADS),
      .FLIT_W (FLIT_W)
   ) u_gather (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (xfer_valid),
      .in_sof      (xfer_sof),
      .in_mode     (lane_mode),
      .in_word     (lane_word),
      .flit_o      (flit),
      .done_o      (done),
      .frame_err_o (ferr_c)
   );

   flit_crc8 #(
      .DATA_W (BODY_W),
      .CRC_W  (CHK_W),
      .POLY   (CHK_POLY)
   ) u_crc (
      .data_i (flit[BODY_W-1:0]),
      .crc_o  (chk_calc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         crc_err     <= 1'b0;
         frame_err   <= 1'b0;
         out_hdr     <= '0;
         out_payload <= '0;
         out_chk     <= '0;
      end else begin
         out_valid <= done;
         frame_err <= ferr_c;
         crc_err   <= done && (chk_calc != flit[FLIT_W-1 -: CHK_W]);
         if (done) begin
            out_payload <= flit[PAYLOAD_W-1:0];
            out_hdr     <= flit[PAYLOAD_W +: HDR_W];
            out_chk     <= flit[FLIT_W-1 -: CHK_W];
         end
      end
   end

endmodule

// File: rtl/flit_rx_deser_chk.sv
module flit_rx_deser_chk (
   input logic clk,
   input logic rst_n,
   input logic xfer_valid,
   input logic xfer_sof,
   input logic out_valid,
   input logic crc_err,
   input logic frame_err
);
   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R8
   err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> out_valid);

   // R9
   valid_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(xfer_valid));

   // R10
   ferr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> $past(xfer_valid && xfer_sof));

   // R10
   ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   // R10
   ferr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_err && out_valid));

endmodule

bind flit_rx_deser flit_rx_deser_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_valid (xfer_valid),
   .xfer_sof   (xfer_sof),
   .out_valid  (out_valid),
   .crc_err    (crc_err),
   .frame_err  (frame_err)
);

// File: tb/test_flit_rx_deser.sv
module test_flit_rx_deser;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  lane_mode = 2'd0;
   logic        xfer_valid = 1'b0;
   logic        xfer_sof = 1'b0;
   logic [19:0] lane_word = '0;
   logic        out_valid, crc_err, frame_err;
   logic [7:0]  out_hdr, out_chk;
   logic [63:0] out_payload;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   flit_rx_deser i_flit_rx_deser (
      .clk         (clk),
      .rst_n       (rst_n),
      .lane_mode   (lane_mode),
      .xfer_valid  (xfer_valid),
      .xfer_sof    (xfer_sof),
      .lane_word   (lane_word),
      .out_valid   (out_valid),
      .out_hdr     (out_hdr),
      .out_payload (out_payload),
      .out_chk     (out_chk),
      .crc_err     (crc_err),
      .frame_err   (frame_err)
   );

   task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_ref(input logic [71:0] d);
      logic [7:0] c = 8'h00;
      for (int i = 71; i >= 0; i--) begin
         logic top = c[7] ^ d[i];
         c = {c[6:0], 1'b0} ^ (top ? 8'h07 : 8'h00);
      end
      return c;
   endfunction

   function automatic logic [79:0] mk_flit(input logic [7:0] h, input logic [63:0] p);
      return {crc_ref({h, p}), h, p};
   endfunction

   function automatic int beats_of(input logic [1:0] m);
      return (m == 2'd0) ? 4 : (m == 2'd1) ? 8 : 16;
   endfunction

   // drive transfer k of flit f in mode m, noise on the idle lanes
   task automatic drive_beat(input logic [79:0] f, input logic [1:0] m, input int k,
                             input logic sof_i, input logic [1:0] mode_drv);
      int w = 80 / beats_of(m);
      lane_word = 20'($urandom);
      for (int b = 0; b < w; b++) lane_word[b] = f[k*w + b];
      xfer_valid = 1'b1;
      xfer_sof   = sof_i;
      lane_mode  = mode_drv;
   endtask

   task automatic send_flit(input logic [79:0] f, input logic [1:0] m, input bit gap,
                            input bit ferr_exp, input bit use_alt, input bit hold,
                            input string tag);
      int nb = beats_of(m);
      logic [1:0] alt = m + 2'd1;
      for (int k = 0; k < nb; k++) begin
         drive_beat(f, m, k, k == 0, (use_alt && k > 0) ? alt : m);
         @(negedge clk);
         if (k == 0) check({tag, " R10 frame_err"}, 80'(frame_err), 80'(ferr_exp));
         if (k < nb - 1) check({tag, " R8 early out_valid"}, 80'(out_valid), 80'd0);
         if (gap && k < nb - 1) begin
            xfer_valid = 1'b0;
            xfer_sof   = 1'b1;
            lane_mode  = 2'($urandom);
            lane_word  = 20'($urandom);
            @(negedge clk);
         end
      end
      check({tag, " R8 out_valid"}, 80'(out_valid), 80'd1);
      check({tag, " R5 R6 payload"}, 80'(out_payload), 80'(f[63:0]));
      check({tag, " R5 R6 header"}, 80'(out_hdr), 80'(f[71:64]));
      check({tag, " R6 check byte"}, 80'(out_chk), 80'(f[79:72]));
      check({tag, " R7 crc_err"}, 80'(crc_err), 80'(crc_ref(f[71:0]) != f[79:72]));
      if (!hold) begin
         xfer_valid = 1'b0;
         xfer_sof   = 1'b0;
         @(negedge clk);
         check({tag, " R8 pulse end"}, 80'(out_valid), 80'd0);
         check({tag, " R8 crc_err end"}, 80'(crc_err), 80'd0);
      end
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [79:0] f;
      string mt;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 out_valid in reset", 80'(out_valid), 80'd0);
      check("R1 crc_err in reset", 80'(crc_err), 80'd0);
      check("R1 frame_err in reset", 80'(frame_err), 80'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 out_valid after reset", 80'(out_valid), 80'd0);
      check("R1 frame_err after reset", 80'(frame_err), 80'd0);

      // R9: stray transfers with no start strobe while idle
      for (int i = 0; i < 20; i++) begin
         xfer_valid = 1'b1;
         xfer_sof   = 1'b0;
         lane_mode  = 2'd0;
         lane_word  = 20'($urandom);
         @(negedge clk);
         check("R9 stray transfer ignored", 80'(out_valid), 80'd0);
      end
      xfer_valid = 1'b0;

      // R2 R3 R4 R7 R11 R12: sweep modes and patterns
      for (int m = 0; m < 4; m++) begin
         mt = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
         for (int i = 0; i < 12; i++) begin
            f = mk_flit(8'($urandom), {32'($urandom), 32'($urandom)});
            if (i % 3 == 0) f[$urandom % 80] ^= 1'b1;
            send_flit(f, 2'(m), i % 4 == 1, 1'b0, i % 5 == 2, i % 2 == 1,
                      (i % 5 == 2) ? {mt, " R11"} : (i % 2 == 1) ? {mt, " R12"} : mt);
         end
      end

      // R7: every single-bit corruption at full width
      for (int b = 0; b < 80; b++) begin
         f = mk_flit(8'($urandom), {32'($urandom), 32'($urandom)});
         f[b] ^= 1'b1;
         send_flit(f, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R2 R7 bitflip");
      end
      xfer_valid = 1'b0;
      @(negedge clk);

      // R10: start strobe mid-flit in each width
      for (int m = 0; m < 3; m++) begin
         f = mk_flit(8'($urandom), {32'($urandom), 32'($urandom)});
         for (int k = 0; k < 3; k++) begin
            drive_beat(~f, 2'(m), k, k == 0, 2'(m));
            @(negedge clk);
         end
         check("R10 no flit from partial", 80'(out_valid), 80'd0);
         send_flit(f, 2'(m), m == 1, 1'b1, 1'b0, 1'b0, "R10 restart");
         check("R10 frame_err one cycle", 80'(frame_err), 80'd0);
      end

      summary();
   end

endmodule